// File: doc/BRIEF.md
# Glitch Trial Sequencer

This block runs a fault-injection campaign against a target device without software in the loop. Each trial holds the target's active-low reset pin low, releases it so the target starts to boot, waits a programmed number of cycles, and then fires one glitch trigger pulse towards an external crowbar circuit. The block then asks an external serial-wire debug master to read one register: the identification register of the memory access port, at access port 0 and register offset 0xFC. The value that comes back decides what happens next. The "still locked" identity starts a new trial. The "unlocked" identity ends the campaign with a success flag. Any other value, or no answer at all, counts as a target fault and the block retries.

Between trials only the reset pin moves, so the target stays powered and its boot timing stays repeatable. The glitch delay sweeps from a minimum to a maximum in programmed steps and wraps back to the minimum. The block reports the number of trials and the number of target faults, and on success the delay of the winning trial. The states are IDLE, HOLD (reset low), WAIT (reset released, counting the delay), PULSE (glitch high), READ (identification read outstanding) and DONE. The transitions are: IDLE or DONE to HOLD on `start`; HOLD to WAIT, WAIT to PULSE and PULSE to READ when the timer of the state expires; READ to DONE on an unlocked answer; READ to HOLD on a locked answer, a foreign answer or a timeout; and any state to IDLE on `abort`.

Top module: `glitch_campaign_seq`

## Requirements
- R1: After `rst_n` is low, and in IDLE, `tgt_rst_n`=1, `glitch`=0, `rd_req`=0, `busy`=0 and `success`=0.
- R2: Every trial begins with `tgt_rst_n` low for exactly `cfg_hold` cycles, with a value of 0 acting as 1. A `start` pulse in IDLE or DONE begins the first trial one cycle later.
- R3: After `tgt_rst_n` rises, `glitch` stays low for exactly the current trial delay in cycles (at least 1) and then rises.
- R4: `glitch` stays high for exactly `cfg_pulse` cycles (0 acts as 1) and is never high while `tgt_rst_n` is low or `rd_req` is high.
- R5: When the pulse ends, `rd_req` rises with `rd_ap`=0 and `rd_addr`=0xFC and stays high until `rd_ack` is sampled high or the timeout expires.
- R6: An acknowledged `rd_data` of 0x23000000 (locked) starts the next trial with the reset hold, and the fault count is unchanged.
- R7: An acknowledged `rd_data` of 0x24770011 (unlocked) enters DONE. There `success`=1, `busy`=0, `tgt_rst_n`=1, `win_delay` holds the delay of that trial, and the state stays until `start` or `abort`.
- R8: Any other acknowledged `rd_data` increments `fault_cnt` and starts the next trial.
- R9: If `rd_ack` does not arrive, `rd_req` stays high for exactly `cfg_timeout` cycles (0 acts as 1). The block then increments `fault_cnt` and starts the next trial.
- R10: The first trial uses `cfg_delay_min`. After each failed trial the delay becomes delay+`cfg_delay_step`, or `cfg_delay_min` when that sum exceeds `cfg_delay_max`.
- R11: `attempts` (32 bits) counts the trials begun since the last `start`. `start` clears `attempts`, `fault_cnt` and `win_delay`.
- R12: `abort` high in any state returns the block to IDLE in the next cycle, with `tgt_rst_n`=1 and `glitch`, `rd_req` and `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| start | input | 1 | Begin a new campaign (accepted in IDLE and DONE) |
| abort | input | 1 | Return to IDLE at once |
| cfg_hold | input | 16 | Cycles with target reset held low |
| cfg_delay_min | input | 16 | First and wrap-back glitch delay |
| cfg_delay_max | input | 16 | Largest glitch delay in the sweep |
| cfg_delay_step | input | 16 | Delay increment after a failed trial |
| cfg_pulse | input | 16 | Glitch pulse width in cycles |
| cfg_timeout | input | 16 | Cycles to wait for the read answer |
| tgt_rst_n | output | 1 | Active-low reset to the target |
| glitch | output | 1 | Glitch trigger to the crowbar circuit |
| rd_req | output | 1 | Read request to the debug master |
| rd_ap | output | 8 | Access port index of the request |
| rd_addr | output | 8 | Register offset of the request |
| rd_ack | input | 1 | Read result valid |
| rd_data | input | 32 | Read result |
| busy | output | 1 | A trial is in progress |
| success | output | 1 | Unlocked identity seen (DONE) |
| attempts | output | 32 | Trials begun in this campaign |
| fault_cnt | output | 32 | Foreign answers and timeouts in this campaign |
| win_delay | output | 16 | Delay of the successful trial |

## Verification
The hardest situation to reach from the ports is the wrap of the delay sweep, because it takes several consecutive failed trials whose answers the bench must time against each new reset cycle. Another hard case is a trial that ends by timeout rather than by an answer. The bench plays the debug master: it watches each trial's reset, delay and pulse lengths, answers with "locked", a foreign value, or nothing, and lets a configured number of trials fail before it returns the unlocked identity. It predicts each trial's delay from the sweep rule, so the wrap, a sum that lands exactly on the maximum, and a minimum equal to the maximum are all measured at the glitch pin.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    localparam int CNT_W = 16;
    localparam int ATT_W = 32;

    localparam logic [7:0]  ID_AP     = 8'h00;
    localparam logic [7:0]  ID_OFFSET = 8'hFC;
    localparam logic [31:0] ID_LOCKED = 32'h2300_0000;
    localparam logic [31:0] ID_OPEN   = 32'h2477_0011;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_PULSE = 3'd3,
        ST_READ  = 3'd4,
        ST_DONE  = 3'd5
    } gcs_state_e;

endpackage

// File: rtl/gcs_phase_timer.sv
// Down-counter that measures the length of one phase; a load of N
// makes done rise in the N-th cycle of the phase (0 behaves as 1).
module gcs_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/gcs_delay_sweep.sv
// Holds the glitch delay of the running trial and steps it with wrap.
module gcs_delay_sweep #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         adv,
    input  logic [W-1:0] dly_min,
    input  logic [W-1:0] dly_max,
    input  logic [W-1:0] dly_step,
    output logic [W-1:0] cur
);
    logic [W:0]   sum;
    logic [W-1:0] cur_q;

    assign sum = {1'b0, cur_q} + {1'b0, dly_step};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (init) begin
            cur_q <= dly_min;
        end else if (adv) begin
            cur_q <= (sum > {1'b0, dly_max}) ? dly_min : sum[W-1:0];
        end
    end

    assign cur = cur_q;
endmodule

// File: rtl/gcs_event_counter.sv
// Clearable event counter; a clear and an increment together give 1.
module gcs_event_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= W'(inc);
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign value = cnt_q;
endmodule

// File: rtl/glitch_campaign_seq.sv
module glitch_campaign_seq
    import gcs_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = ATT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [CW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_delay_min,
    input  logic [CW-1:0] cfg_delay_max,
    input  logic [CW-1:0] cfg_delay_step,
    input  logic [CW-1:0] cfg_pulse,
    input  logic [CW-1:0] cfg_timeout,
    output logic          tgt_rst_n,
    output logic          glitch,
    output logic          rd_req,
    output logic [7:0]    rd_ap,
    output logic [7:0]    rd_addr,
    input  logic          rd_ack,
    input  logic [31:0]   rd_data,
    output logic          busy,
    output logic          success,
    output logic [AW-1:0] attempts,
    output logic [AW-1:0] fault_cnt,
    output logic [CW-1:0] win_delay
);
    gcs_state_e    state_q, state_d;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          sw_init, sw_adv;
    logic [CW-1:0] cur_delay;
    logic          att_clr, att_inc;
    logic          flt_inc;
    logic          win_cap, win_clr;
    logic [CW-1:0] win_q;

    gcs_phase_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    gcs_delay_sweep #(.W(CW)) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (sw_init),
        .adv      (sw_adv),
        .dly_min  (cfg_delay_min),
        .dly_max  (cfg_delay_max),
        .dly_step (cfg_delay_step),
        .cur      (cur_delay)
    );

    gcs_event_counter #(.W(AW)) u_attempts (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (att_clr),
        .inc   (att_inc),
        .value (attempts)
    );

    gcs_event_counter #(.W(AW)) u_faults (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (att_clr),
        .inc   (flt_inc),
        .value (fault_cnt)
    );

    // Transition logic
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = cfg_hold;
        sw_init  = 1'b0;
        sw_adv   = 1'b0;
        att_clr  = 1'b0;
        att_inc  = 1'b0;
        flt_inc  = 1'b0;
        win_cap  = 1'b0;
        win_clr  = 1'b0;
        if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state_d  = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = cfg_hold;
                        sw_init  = 1'b1;
                        att_clr  = 1'b1;
                        att_inc  = 1'b1;
                        win_clr  = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (tmr_done) begin
                        state_d  = ST_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = cur_delay;
                    end
                end
                ST_WAIT: begin
                    if (tmr_done) begin
                        state_d  = ST_PULSE;
                        tmr_load = 1'b1;
                        tmr_val  = cfg_pulse;
                    end
                end
                ST_PULSE: begin
                    if (tmr_done) begin
                        state_d  = ST_READ;
                        tmr_load = 1'b1;
                        tmr_val  = cfg_timeout;
                    end
                end
                ST_READ: begin
                    if (rd_ack && rd_data == ID_OPEN) begin
                        state_d = ST_DONE;
                        win_cap = 1'b1;
                    end else if (rd_ack || tmr_done) begin
                        state_d  = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = cfg_hold;
                        sw_adv   = 1'b1;
                        att_inc  = 1'b1;
                        flt_inc  = !(rd_ack && rd_data == ID_LOCKED);
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register and captured winning delay
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            if (win_clr) begin
                win_q <= '0;
            end else if (win_cap) begin
                win_q <= cur_delay;
            end
        end
    end

    // Moore outputs
    always_comb begin
        tgt_rst_n = 1'b1;
        glitch    = 1'b0;
        rd_req    = 1'b0;
        busy      = 1'b0;
        success   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_HOLD:  begin tgt_rst_n = 1'b0; busy = 1'b1; end
            ST_WAIT:  busy = 1'b1;
            ST_PULSE: begin glitch = 1'b1; busy = 1'b1; end
            ST_READ:  begin rd_req = 1'b1; busy = 1'b1; end
            ST_DONE:  success = 1'b1;
            default:  ;
        endcase
    end

    assign rd_ap     = ID_AP;
    assign rd_addr   = ID_OFFSET;
    assign win_delay = win_q;

endmodule

// File: rtl/gcs_checker.sv
module gcs_checker #(
    parameter int CW = 16,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          abort,
    input logic          tgt_rst_n,
    input logic          glitch,
    input logic          rd_req,
    input logic [7:0]    rd_ap,
    input logic [7:0]    rd_addr,
    input logic          busy,
    input logic          success,
    input logic [AW-1:0] attempts,
    input logic [CW-1:0] win_delay
);
    AST_GLITCH_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        glitch |-> (tgt_rst_n && !rd_req)); // R4

    AST_REQ_TARGETS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_ap == 8'h00 && rd_addr == 8'hFC)); // R5

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (tgt_rst_n && !glitch && !rd_req && !busy && !success)); // R12

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (success && !abort && !start) |=> success); // R7

    AST_WIN_DELAY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (success && $past(success)) |-> $stable(win_delay)); // R7

    AST_ATTEMPT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (attempts == $past(attempts) || attempts == $past(attempts) + 1'b1
         || attempts == 1)); // R11

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        success |-> (!busy && tgt_rst_n)); // R7
endmodule

bind glitch_campaign_seq gcs_checker #(.CW(CW), .AW(AW)) u_gcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .abort     (abort),
    .tgt_rst_n (tgt_rst_n),
    .glitch    (glitch),
    .rd_req    (rd_req),
    .rd_ap     (rd_ap),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .success   (success),
    .attempts  (attempts),
    .win_delay (win_delay)
);

// File: tb/tb_glitch_campaign_seq.sv
module tb_glitch_campaign_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [15:0] cfg_hold = 16'd1, cfg_delay_min = 16'd1, cfg_delay_max = 16'd1;
    logic [15:0] cfg_delay_step = 16'd1, cfg_pulse = 16'd1, cfg_timeout = 16'd4;
    logic        tgt_rst_n, glitch, rd_req, busy, success;
    logic [7:0]  rd_ap, rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic [31:0] attempts, fault_cnt;
    logic [15:0] win_delay;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    glitch_campaign_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .cfg_hold(cfg_hold), .cfg_delay_min(cfg_delay_min),
        .cfg_delay_max(cfg_delay_max), .cfg_delay_step(cfg_delay_step),
        .cfg_pulse(cfg_pulse), .cfg_timeout(cfg_timeout),
        .tgt_rst_n(tgt_rst_n), .glitch(glitch), .rd_req(rd_req),
        .rd_ap(rd_ap), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .success(success), .attempts(attempts),
        .fault_cnt(fault_cnt), .win_delay(win_delay)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // kind: 0 locked answer, 1 foreign answer, 2 no answer (timeout)
    typedef struct packed {
        logic [15:0] hold;
        logic [15:0] dmin;
        logic [15:0] dmax;
        logic [15:0] step;
        logic [15:0] pulse;
        logic [7:0]  fails;
        logic [1:0]  kind;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{16'd3, 16'd2, 16'd6, 16'd2, 16'd1, 8'd0, 2'd0, 4'd0},
        '{16'd1, 16'd4, 16'd8, 16'd2, 16'd2, 8'd4, 2'd0, 4'd2},
        '{16'd5, 16'd1, 16'd3, 16'd1, 16'd3, 8'd3, 2'd1, 4'd1},
        '{16'd2, 16'd3, 16'd3, 16'd5, 16'd1, 8'd2, 2'd2, 4'd0},
        '{16'd0, 16'd2, 16'd9, 16'd3, 16'd0, 8'd3, 2'd0, 4'd0}
    };

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        int exp_delay;
        int exp_faults;
        cfg_hold = v.hold; cfg_delay_min = v.dmin; cfg_delay_max = v.dmax;
        cfg_delay_step = v.step; cfg_pulse = v.pulse; cfg_timeout = 16'd4;
        exp_delay = v.dmin;
        exp_faults = 0;
        pulse_start();
        for (int t = 0; t <= int'(v.fails); t++) begin
            int n, d, p, r;
            while (tgt_rst_n) @(negedge clk);
            n = 0;
            while (!tgt_rst_n) begin n++; @(negedge clk); end
            check("R2 hold length", n, (v.hold == 0) ? 1 : v.hold);
            check("R11 attempts", attempts, t + 1);
            d = 0;
            while (!glitch) begin d++; @(negedge clk); end
            check("R3/R10 delay", d, (exp_delay == 0) ? 1 : exp_delay);
            p = 0;
            while (glitch) begin p++; @(negedge clk); end
            check("R4 pulse width", p, (v.pulse == 0) ? 1 : v.pulse);
            check("R5 request", {rd_req, rd_ap, rd_addr}, {1'b1, 8'h00, 8'hFC});
            if (t < int'(v.fails) && v.kind == 2'd2) begin
                r = 0;
                while (rd_req) begin r++; @(negedge clk); end
                check("R9 timeout length", r, 4);
                exp_faults++;
            end else begin
                repeat (int'(v.lat)) @(negedge clk);
                check("R5 request held", rd_req, 1);
                rd_ack = 1'b1;
                if (t == int'(v.fails)) rd_data = 32'h2477_0011;
                else if (v.kind == 2'd0) rd_data = 32'h2300_0000;
                else begin rd_data = 32'hDEAD_0000 + t; exp_faults++; end
                @(negedge clk);
                rd_ack = 1'b0;
            end
            if (t < int'(v.fails)) begin
                check(v.kind == 2'd0 ? "R6 faults" : "R8/R9 faults", fault_cnt, exp_faults);
                exp_delay = ((exp_delay + v.step) > v.dmax) ? v.dmin : exp_delay + v.step;
            end
        end
        check("R7 success", {success, busy, tgt_rst_n, glitch}, 4'b1010);
        check("R7 win_delay", win_delay, exp_delay);
        check("R11 total attempts", attempts, v.fails + 1);
        check("R8 total faults", fault_cnt, exp_faults);
        repeat (3) @(negedge clk);
        check("R7 done held", {success, win_delay}, {1'b1, 16'(exp_delay)});
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {tgt_rst_n, glitch, rd_req, busy, success}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle outputs", {tgt_rst_n, glitch, rd_req, busy, success}, 5'b10000);
        check("R1 idle counters", attempts, 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R12: abort during the glitch pulse
        cfg_hold = 16'd2; cfg_delay_min = 16'd3; cfg_delay_max = 16'd3;
        cfg_delay_step = 16'd1; cfg_pulse = 16'd5;
        pulse_start();
        check("R11 start clears", {attempts, win_delay}, {32'd1, 16'd0});
        while (!glitch) @(negedge clk);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        check("R12 abort in pulse", {tgt_rst_n, glitch, rd_req, busy, success}, 5'b10000);
        repeat (3) @(negedge clk);
        check("R12 stays idle", {tgt_rst_n, busy}, 2'b10);

        // R12: abort while target reset is held
        pulse_start();
        check("R2 reset low after start", tgt_rst_n, 0);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        check("R12 abort in hold", {tgt_rst_n, glitch, busy}, 3'b100);

        // R1: block reset in the middle of a trial
        pulse_start();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-trial", {tgt_rst_n, glitch, rd_req, busy, success}, 5'b10000);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule